// File: doc/BRIEF.md
# Strided Banked Vector Memory Sequencer

This block turns one vector memory command into a stream of element accesses. A command gives a base word address, a stride and an element count. Each cycle the sequencer offers at most one element request to a memory of word-interleaved, single-ported banks. Element `i` goes to word address `base + i*stride`, and the bank is picked by the low address bits. Every bank stays occupied for a fixed number of cycles after an access starts. When the next element falls on a bank that is still occupied, the sequencer holds that element and raises a stall flag until the bank frees. It never skips ahead to a later element.

The memory answers each request after a fixed latency. The sequencer keeps a delay line of element tags so that every returned word is written back with its element index, in element order. A one-cycle done pulse marks the last write-back. A zero-length command finishes at once.

Control is a three-state machine. `ST_IDLE` waits for a command. It moves to `ST_ISSUE` on a start with a non-zero length, or stays put and pulses done on a zero-length start. `ST_ISSUE` steps through the elements and moves to `ST_DRAIN` when it issues the last element. `ST_DRAIN` waits for the last tagged return and then goes back to `ST_IDLE`.

Top module: `vmem_seq`

## Requirements
- R1: Element `i` of a command is requested at word address `(base + i*stride) mod 2^ADDR_W`, with `req_elem_o = i`. Elements are issued in increasing index order with no gaps or repeats.
- R2: `req_bank_o` equals the low 4 bits of `req_addr_o` (16 banks, word interleaved).
- R3: Two requests to the same bank are never fewer than 4 cycles apart. A stride that is a multiple of 16, including stride 0, produces exactly one request every 4 cycles.
- R4: While the pending element's bank is occupied, `stall_o` is 1, `req_valid_o` is 0, and the pending address is held. The element issues in the first cycle its bank is free again.
- R5: A command whose stride never revisits a bank within 4 consecutive elements (for example stride 1, 3 or -1) issues one element per cycle, starting the cycle after the start is accepted, and never raises `stall_o`.
- R6: Every returned word appears on `wb_data_o` with its element index on `wb_elem_o`, exactly 13 cycles after that element's request cycle (LATENCY 12, plus one register), in element order.
- R7: `done_o` pulses high for one cycle, in the same cycle as the last element's write-back. `busy_o` is 0 in that cycle. Without conflicts this is LATENCY + length cycles after the first request.
- R8: A start with length 0 pulses `done_o` in the next cycle, issues no request and leaves `busy_o` at 0.
- R9: A start pulse while `busy_o` is 1 is ignored: the running command's addresses, count and completion are unchanged.
- R10: After reset, `busy_o`, `req_valid_o`, `stall_o`, `wb_valid_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, accepted only while idle |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Address step between elements (two's complement wraps) |
| len_i | input | LEN_W | Number of elements |
| busy_o | output | 1 | Command in progress (issue or drain) |
| req_valid_o | output | 1 | Element request issued this cycle |
| req_addr_o | output | ADDR_W | Word address of the pending element |
| req_bank_o | output | BANK_W | Bank index of the pending element |
| req_elem_o | output | LEN_W | Index of the pending element |
| stall_o | output | 1 | Pending element blocked by an occupied bank |
| rsp_valid_i | input | 1 | Memory return strobe, LATENCY cycles after a request |
| rsp_data_i | input | DATA_W | Memory return data |
| wb_valid_o | output | 1 | Write-back of one element |
| wb_elem_o | output | LEN_W | Element index of the write-back |
| wb_data_o | output | DATA_W | Data of the write-back |
| done_o | output | 1 | One-cycle pulse at command completion |

## Verification
The bench targets the stride patterns that decide bank reuse. Stride 8 revisits a bank after two elements. A sequencer that ignores the occupancy timer would break bank spacing, and one that drops or reorders the blocked element would produce the wrong address order. Strides 16, 32 and 0 pin every access to a single bank; an off-by-one in the timer would show up as a spacing of 3 or 5 cycles instead of 4. Address wrap past the top of the space and a negative stride test the adder width. Zero-length commands and start pulses during a running command would hang the control, or restart it, if the idle decode were wrong. Exact write-back and done cycles expose any miscount in the latency delay line.

// File: rtl/vmem_seq_pkg.sv
package vmem_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vmem_addr_gen.sv
module vmem_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  elem_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  elem_q;

    // Address steps by the stored stride; the sum wraps at ADDR_W bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
            len_q    <= '0;
            elem_q   <= '0;
        end else if (load_i) begin
            addr_q   <= base_i;
            stride_q <= stride_i;
            len_q    <= len_i;
            elem_q   <= '0;
        end else if (adv_i) begin
            addr_q   <= addr_q + stride_q;
            elem_q   <= elem_q + LEN_W'(1);
        end
    end

    assign addr_o = addr_q;
    assign elem_o = elem_q;
    assign last_o = (elem_q == len_q - LEN_W'(1));

endmodule

// File: rtl/vmem_bank_timers.sv
module vmem_bank_timers #(
    parameter int NUM_BANKS = 16,
    parameter int BANK_BUSY = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic                         issue_i,
    output logic                         free_o
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2(BANK_BUSY) + 1;

    logic [CNT_W-1:0] remain [NUM_BANKS];

    // One occupancy down-counter per bank; zero means the bank accepts an access.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                remain[b] <= '0;
            end else if (issue_i && (bank_i == BANK_W'(b))) begin
                remain[b] <= CNT_W'(BANK_BUSY - 1);
            end else if (remain[b] != '0) begin
                remain[b] <= remain[b] - CNT_W'(1);
            end
        end
    end

    assign free_o = (remain[bank_i] == '0);

endmodule

// File: rtl/vmem_return_track.sv
module vmem_return_track #(
    parameter int LEN_W   = 7,
    parameter int DATA_W  = 16,
    parameter int LATENCY = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [LEN_W-1:0]  push_elem_i,
    input  logic              push_last_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              tail_last_o,
    output logic              wb_valid_o,
    output logic [LEN_W-1:0]  wb_elem_o,
    output logic [DATA_W-1:0] wb_data_o,
    output logic              wb_last_o
);

    logic [LATENCY-1:0] tag_v;
    logic [LATENCY-1:0] tag_l;
    logic [LEN_W-1:0]   tag_e [LATENCY];

    // Tag delay line: stage k holds the request issued k+1 cycles ago.
    for (genvar k = 0; k < LATENCY; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_v[k] <= 1'b0;
                    tag_l[k] <= 1'b0;
                    tag_e[k] <= '0;
                end else begin
                    tag_v[k] <= push_i;
                    tag_l[k] <= push_i & push_last_i;
                    tag_e[k] <= push_elem_i;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_v[k] <= 1'b0;
                    tag_l[k] <= 1'b0;
                    tag_e[k] <= '0;
                end else begin
                    tag_v[k] <= tag_v[k-1];
                    tag_l[k] <= tag_l[k-1];
                    tag_e[k] <= tag_e[k-1];
                end
            end
        end
    end

    assign tail_last_o = tag_v[LATENCY-1] & tag_l[LATENCY-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_valid_o <= 1'b0;
            wb_last_o  <= 1'b0;
            wb_elem_o  <= '0;
            wb_data_o  <= '0;
        end else begin
            wb_valid_o <= tag_v[LATENCY-1] & rsp_valid_i;
            wb_last_o  <= tail_last_o;
            wb_elem_o  <= tag_e[LATENCY-1];
            wb_data_o  <= rsp_data_i;
        end
    end

endmodule

// File: rtl/vmem_seq.sv
module vmem_seq
    import vmem_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int LEN_W     = 7,
    parameter int NUM_BANKS = 16,
    parameter int BANK_BUSY = 4,
    parameter int LATENCY   = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [ADDR_W-1:0]            base_i,
    input  logic [ADDR_W-1:0]            stride_i,
    input  logic [LEN_W-1:0]             len_i,
    output logic                         busy_o,
    output logic                         req_valid_o,
    output logic [ADDR_W-1:0]            req_addr_o,
    output logic [$clog2(NUM_BANKS)-1:0] req_bank_o,
    output logic [LEN_W-1:0]             req_elem_o,
    output logic                         stall_o,
    input  logic                         rsp_valid_i,
    input  logic [DATA_W-1:0]            rsp_data_i,
    output logic                         wb_valid_o,
    output logic [LEN_W-1:0]             wb_elem_o,
    output logic [DATA_W-1:0]            wb_data_o,
    output logic                         done_o
);

    localparam int BANK_W = $clog2(NUM_BANKS);

    seq_state_e        state_q, state_d;
    logic              accept;
    logic              issue;
    logic              bank_free;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_elem;
    logic              cur_last;
    logic              tail_last;
    logic              wb_last;
    logic              zero_done_q;

    assign accept = (state_q == ST_IDLE) && start_i;

    vmem_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .base_i   (base_i),
        .stride_i (stride_i),
        .len_i    (len_i),
        .adv_i    (issue),
        .addr_o   (cur_addr),
        .elem_o   (cur_elem),
        .last_o   (cur_last)
    );

    vmem_bank_timers #(.NUM_BANKS(NUM_BANKS), .BANK_BUSY(BANK_BUSY)) u_timers (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_i  (cur_addr[BANK_W-1:0]),
        .issue_i (issue),
        .free_o  (bank_free)
    );

    vmem_return_track #(.LEN_W(LEN_W), .DATA_W(DATA_W), .LATENCY(LATENCY)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (issue),
        .push_elem_i (cur_elem),
        .push_last_i (cur_last),
        .rsp_valid_i (rsp_valid_i),
        .rsp_data_i  (rsp_data_i),
        .tail_last_o (tail_last),
        .wb_valid_o  (wb_valid_o),
        .wb_elem_o   (wb_elem_o),
        .wb_data_o   (wb_data_o),
        .wb_last_o   (wb_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i && (len_i != '0)) state_d = ST_ISSUE;
            ST_ISSUE: if (issue && cur_last)        state_d = ST_DRAIN;
            ST_DRAIN: if (tail_last)                state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o  = 1'b0;
        issue   = 1'b0;
        stall_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                busy_o  = 1'b1;
                issue   = bank_free;
                stall_o = !bank_free;
            end
            ST_DRAIN: busy_o = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_done_q <= 1'b0;
        end else begin
            zero_done_q <= accept && (len_i == '0);
        end
    end

    assign req_valid_o = issue;
    assign req_addr_o  = cur_addr;
    assign req_bank_o  = cur_addr[BANK_W-1:0];
    assign req_elem_o  = cur_elem;
    assign done_o      = zero_done_q | (wb_valid_o & wb_last);

endmodule

// File: rtl/vmem_seq_chk.sv
module vmem_seq_chk #(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 7,
    parameter int NUM_BANKS = 16,
    parameter int BANK_BUSY = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start_i,
    input logic [ADDR_W-1:0]            stride_i,
    input logic [LEN_W-1:0]             len_i,
    input logic                         busy_o,
    input logic                         req_valid_o,
    input logic [ADDR_W-1:0]            req_addr_o,
    input logic [$clog2(NUM_BANKS)-1:0] req_bank_o,
    input logic [LEN_W-1:0]             req_elem_o,
    input logic                         stall_o,
    input logic                         wb_valid_o,
    input logic [LEN_W-1:0]             wb_elem_o,
    input logic                         done_o
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int GAP_W  = $clog2(BANK_BUSY) + 1;

    logic              take;
    logic [ADDR_W-1:0] stride_c;
    logic [ADDR_W-1:0] prev_addr;
    logic [LEN_W-1:0]  prev_elem;
    logic              have_prev;
    logic [LEN_W-1:0]  prev_wb;
    logic              have_wb;
    logic [ADDR_W-1:0] next_addr;
    logic [GAP_W-1:0]  gap [NUM_BANKS];

    assign take      = start_i && !busy_o;
    assign next_addr = prev_addr + stride_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stride_c  <= '0;
            prev_addr <= '0;
            prev_elem <= '0;
            have_prev <= 1'b0;
            prev_wb   <= '0;
            have_wb   <= 1'b0;
        end else begin
            if (take) begin
                stride_c  <= stride_i;
                have_prev <= 1'b0;
                have_wb   <= 1'b0;
            end
            if (req_valid_o) begin
                prev_addr <= req_addr_o;
                prev_elem <= req_elem_o;
                have_prev <= 1'b1;
            end
            if (wb_valid_o) begin
                prev_wb <= wb_elem_o;
                have_wb <= 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gap[b] <= GAP_W'(BANK_BUSY);
            end else if (req_valid_o && (req_bank_o == BANK_W'(b))) begin
                gap[b] <= GAP_W'(1);
            end else if (gap[b] < GAP_W'(BANK_BUSY)) begin
                gap[b] <= gap[b] + GAP_W'(1);
            end
        end

        // R3
        bank_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid_o && (req_bank_o == BANK_W'(b))) |-> (gap[b] >= GAP_W'(BANK_BUSY)));
    end

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && have_prev) |-> (req_addr_o == next_addr));

    // R1
    elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && have_prev) |-> (req_elem_o == prev_elem + LEN_W'(1)));

    // R4
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> !req_valid_o);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> ($stable(req_addr_o) && $stable(req_elem_o)));

    // R6
    wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && have_wb) |-> (wb_elem_o == prev_wb + LEN_W'(1)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !req_valid_o));

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (len_i == '0)) |=> (done_o && !req_valid_o && !busy_o));

endmodule

bind vmem_seq vmem_seq_chk #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .NUM_BANKS (NUM_BANKS),
    .BANK_BUSY (BANK_BUSY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stride_i    (stride_i),
    .len_i       (len_i),
    .busy_o      (busy_o),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .req_bank_o  (req_bank_o),
    .req_elem_o  (req_elem_o),
    .stall_o     (stall_o),
    .wb_valid_o  (wb_valid_o),
    .wb_elem_o   (wb_elem_o),
    .done_o      (done_o)
);

// File: tb/vmem_seq_tb.sv
`timescale 1ns/1ps
module vmem_seq_tb;

    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int LW  = 7;
    localparam int LAT = 12;
    localparam int BSY = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW-1:0] stride_i = '0;
    logic [LW-1:0] len_i = '0;
    logic          busy_o, req_valid_o, stall_o, wb_valid_o, done_o;
    logic [AW-1:0] req_addr_o;
    logic [3:0]    req_bank_o;
    logic [LW-1:0] req_elem_o, wb_elem_o;
    logic [DW-1:0] wb_data_o;
    logic          rsp_valid_i;
    logic [DW-1:0] rsp_data_i;

    always #10 clk = ~clk;

    vmem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .stride_i(stride_i), .len_i(len_i), .busy_o(busy_o),
        .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .req_bank_o(req_bank_o), .req_elem_o(req_elem_o), .stall_o(stall_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .wb_valid_o(wb_valid_o), .wb_elem_o(wb_elem_o), .wb_data_o(wb_data_o),
        .done_o(done_o)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return a ^ 16'h5A3C;
    endfunction

    // Behavioural banks: fixed-latency return of each request.
    logic          mdl_v [LAT];
    logic [AW-1:0] mdl_a [LAT];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) begin
                mdl_v[k] <= 1'b0;
                mdl_a[k] <= '0;
            end
        end else begin
            mdl_v[0] <= req_valid_o;
            mdl_a[0] <= req_addr_o;
            for (int k = 1; k < LAT; k++) begin
                mdl_v[k] <= mdl_v[k-1];
                mdl_a[k] <= mdl_a[k-1];
            end
        end
    end
    assign rsp_valid_i = mdl_v[LAT-1];
    assign rsp_data_i  = mem_word(mdl_a[LAT-1]);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    // Monitor, sampled mid-cycle
    int            nreq, nwb, ndone, nstall, done_cyc;
    logic          done_busy;
    int            rq_cyc [128];
    logic [AW-1:0] rq_addr [128];
    logic [3:0]    rq_bank [128];
    logic [LW-1:0] rq_elem [128];
    int            wb_cyc [128];
    logic [LW-1:0] wbe [128];
    logic [DW-1:0] wbd [128];

    always @(negedge clk) begin
        if (req_valid_o && nreq < 128) begin
            rq_cyc[nreq]  = cyc;
            rq_addr[nreq] = req_addr_o;
            rq_bank[nreq] = req_bank_o;
            rq_elem[nreq] = req_elem_o;
            nreq++;
        end
        if (wb_valid_o && nwb < 128) begin
            wb_cyc[nwb] = cyc;
            wbe[nwb]    = wb_elem_o;
            wbd[nwb]    = wb_data_o;
            nwb++;
        end
        if (stall_o) nstall++;
        if (done_o) begin
            if (ndone == 0) begin
                done_cyc  = cyc;
                done_busy = busy_o;
            end
            ndone++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        nreq = 0; nwb = 0; ndone = 0; nstall = 0; done_cyc = -1; done_busy = 1'b0;
    endtask

    // Runs one command; junk_at > 0 injects a start pulse that must be ignored.
    task automatic run_cmd(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                           input int len, input int junk_at, input string req);
        int s, t, tl, stalls;
        int last_b [16];
        int t_exp [128];
        logic [AW-1:0] ea;
        bit fin;
        clear_mon();
        @(negedge clk);
        base_i = base; stride_i = stride; len_i = LW'(len); start_i = 1'b1;
        s = cyc;
        @(negedge clk);
        start_i = 1'b0;
        fin = 1'b0;
        for (int k = 0; k < 2000 && !fin; k++) begin
            @(negedge clk); #1;
            if (ndone > 0) fin = 1'b1;
            if (junk_at > 0 && k == junk_at) begin
                base_i = 16'hDEAD; stride_i = 16'h0007; len_i = 7'd5; start_i = 1'b1;
            end
            if (junk_at > 0 && k == junk_at + 1) start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(fin, req, "command completes", fin, 1);
        repeat (3) @(negedge clk);
        #1;
        // Independent expected issue schedule
        for (int b = 0; b < 16; b++) last_b[b] = -1000;
        t = s;
        for (int i = 0; i < len; i++) begin
            ea = base + stride * 16'(i);
            tl = t + 1;
            if (last_b[ea[3:0]] + BSY > tl) tl = last_b[ea[3:0]] + BSY;
            t_exp[i] = tl;
            last_b[ea[3:0]] = tl;
            t = tl;
        end
        stalls = t - (s + 1) - (len - 1);
        chk(nreq == len, "R1", {req, " request count"}, nreq, len);
        chk(nwb == len, "R6", {req, " write-back count"}, nwb, len);
        for (int i = 0; i < len && i < nreq; i++) begin
            ea = base + stride * 16'(i);
            chk(rq_addr[i] == ea, "R1", {req, " element address"}, rq_addr[i], ea);
            chk(rq_elem[i] == LW'(i), "R1", {req, " element index"}, rq_elem[i], i);
            chk(rq_bank[i] == ea[3:0], "R2", {req, " bank index"}, rq_bank[i], ea[3:0]);
            chk(rq_cyc[i] == t_exp[i], "R4", {req, " issue cycle"}, rq_cyc[i] - s, t_exp[i] - s);
        end
        for (int i = 0; i < len && i < nwb; i++) begin
            ea = base + stride * 16'(i);
            chk(wbe[i] == LW'(i), "R6", {req, " write-back order"}, wbe[i], i);
            chk(wbd[i] == mem_word(ea), "R6", {req, " write-back data"}, wbd[i], mem_word(ea));
            chk(wb_cyc[i] == t_exp[i] + LAT + 1, "R6", {req, " write-back cycle"},
                wb_cyc[i] - s, t_exp[i] + LAT + 1 - s);
        end
        chk(nstall == stalls, "R4", {req, " stall cycles"}, nstall, stalls);
        chk(ndone == 1, "R7", {req, " single done pulse"}, ndone, 1);
        chk(done_cyc == t + LAT + 1, "R7", {req, " done cycle"}, done_cyc - s, t + LAT + 1 - s);
        chk(done_busy == 1'b0, "R7", {req, " idle at done"}, done_busy, 0);
    endtask

    task automatic test_reset();
        // R10
        chk(busy_o == 0, "R10", "busy after reset", busy_o, 0);
        chk(req_valid_o == 0, "R10", "req_valid after reset", req_valid_o, 0);
        chk(stall_o == 0, "R10", "stall after reset", stall_o, 0);
        chk(wb_valid_o == 0, "R10", "wb_valid after reset", wb_valid_o, 0);
        chk(done_o == 0, "R10", "done after reset", done_o, 0);
    endtask

    task automatic test_unit_stride();
        // R5 R7: 50 elements, no conflicts, done = first request + LAT + 50
        run_cmd(16'h0100, 16'd1, 50, 0, "R5 unit stride");
        chk(nstall == 0, "R5", "unit stride never stalls", nstall, 0);
        chk(done_cyc - rq_cyc[0] == LAT + 50, "R7", "unit stride completion",
            done_cyc - rq_cyc[0], LAT + 50);
    endtask

    task automatic test_same_bank(input logic [AW-1:0] stride, input string req);
        // R3: every element in one bank, spacing exactly 4
        run_cmd(16'h0043, stride, 8, 0, req);
        for (int i = 1; i < nreq; i++)
            chk(rq_cyc[i] - rq_cyc[i-1] == BSY, "R3", {req, " spacing"},
                rq_cyc[i] - rq_cyc[i-1], BSY);
    endtask

    task automatic test_zero_len();
        // R8
        clear_mon();
        @(negedge clk);
        base_i = 16'h0200; stride_i = 16'd1; len_i = '0; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        chk(done_o == 1'b1, "R8", "done next cycle", done_o, 1);
        chk(busy_o == 1'b0, "R8", "not busy", busy_o, 0);
        repeat (LAT + 4) @(negedge clk);
        #1;
        chk(nreq == 0, "R8", "no requests", nreq, 0);
        chk(ndone == 1, "R8", "single done", ndone, 1);
    endtask

    initial begin
        #(20ns * 150000);
        chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_unit_stride();
        test_same_bank(16'd16, "R3 stride16");
        test_same_bank(16'd32, "R3 stride32");
        test_same_bank(16'd0,  "R3 stride0");
        run_cmd(16'h0010, 16'd8, 10, 0, "R4 stride8 conflicts");
        chk(nstall > 0, "R4", "stride 8 stalls", nstall, 1);
        run_cmd(16'hFFF0, 16'd3, 20, 0, "R1 wrap stride3");
        chk(nstall == 0, "R5", "stride 3 no stall", nstall, 0);
        run_cmd(16'h0005, 16'hFFFF, 20, 0, "R5 negative stride");
        chk(nstall == 0, "R5", "negative stride no stall", nstall, 0);
        test_zero_len();
        run_cmd(16'h0300, 16'd1, 20, 5, "R9 start ignored in issue");
        run_cmd(16'h0400, 16'd2, 6, 12, "R9 start ignored in drain");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule